// File: doc/BRIEF.md
# Dual-Mode Programmable Feedback Divider

The block divides a counter clock, which comes from the VCO prescaler, by a ratio taken from a 17-bit divider word. It gives one single-cycle pulse per division period, and that pulse drives a phase detector. A mode input selects how the word is read. In the wide mode (FM) all 17 bits form the ratio. In the narrow mode (AM) the two lowest bits are dropped, so the ratio is the upper 15 bits. Each mode has a minimum ratio, and any smaller value is raised to that minimum.

The ratio is read only when the counter reloads. A new word or a new mode therefore never shortens or stretches the period already in progress.

A 3-bit test code selects what drives the band-switch pin: the divider pulse, an external reference-divider pulse, or the normal software band-switch bit. The same code can also force the charge pump into a fixed state.

Top module: `prog_divider`

## Requirements
- R1: While reset is low, `mainTick` is 0. After reset is released, the first pulse is high in the cycle that follows the N-th rising clock edge.
- R2: With `fmMode`=1, the ratio N is the full `divWord`, and pulses repeat every N clock cycles.
- R3: With `fmMode`=0, N is `divWord[16:2]`, and bits 1:0 of `divWord` have no effect on the period.
- R4: With `fmMode`=1, any ratio below 256 is used as 256.
- R5: With `fmMode`=0, any ratio below 64 is used as 64.
- R6: `divWord` and `fmMode` are sampled only at a reload. A reload happens in the cycle in which `mainTick` is high. A change made earlier in the period takes effect from the next period.
- R7: `mainTick` is high for exactly one clock cycle per period.
- R8: `testSel`=5 puts `mainTick` on `bandOut`. `testSel`=6 puts `refTick` on `bandOut`. Every other code puts `bandSel` on `bandOut`.
- R9: The charge-pump override outputs {`pumpForce`,`pumpUp`,`pumpDn`} are set by `testSel`:
  - 1 gives source only, {1,1,0}.
  - 2 gives sink only, {1,0,1}.
  - 3 gives high impedance, {1,0,0}.
  - 4 gives source plus sink, {1,1,1}.
  - Every other code gives {0,0,0}.
- R10: Codes 0 and 7 are normal operation. No override is active, and `bandOut` follows `bandSel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock from the VCO prescaler |
| rstN | input | 1 | Asynchronous reset, active low |
| divWord | input | 17 | Divider word |
| fmMode | input | 1 | 1 = wide mode, all bits used; 0 = narrow mode, bits 1:0 dropped |
| bandSel | input | 1 | Software band-switch bit |
| testSel | input | 3 | Test code |
| refTick | input | 1 | Pulse from the reference divider |
| mainTick | output | 1 | One-cycle pulse per division period |
| bandOut | output | 1 | Band-switch pin drive |
| pumpForce | output | 1 | Charge-pump override active |
| pumpUp | output | 1 | Forced source current |
| pumpDn | output | 1 | Forced sink current |

## Verification
The divider is run with several wide-mode words above the minimum and one word below it. The periods measured for these separate honest division from clamping. Two narrow-mode words differ only in their two lowest bits, which shows whether those bits are really dropped. One word is below 64 after the shift, which tests the narrow-mode clamp. The word is changed in the middle of a period, and the period lengths on either side show whether the update waits for the reload. All eight test codes are walked with `refTick` and `bandSel` toggling. This separates each mux source and each charge-pump override.

// File: rtl/divpkg.sv
package divpkg;
  typedef struct packed {
    logic load;
    logic tickSet;
  } divStrobe_t;

  typedef enum logic [2:0] {
    TC_NORMAL  = 3'd0,
    TC_SRC     = 3'd1,
    TC_SNK     = 3'd2,
    TC_HIZ     = 3'd3,
    TC_BOTH    = 3'd4,
    TC_BSMAIN  = 3'd5,
    TC_BSREF   = 3'd6,
    TC_NORMAL2 = 3'd7
  } testCode_t;
endpackage

// File: rtl/div_ctrl.sv
module div_ctrl (
  input  logic cntIsZero,
  input  logic cntIsOne,
  input  logic cntIsTwo,
  output divpkg::divStrobe_t strobe
);
  // Reload on the terminal count, or from the cleared reset state.
  // The tick register is armed one count before the terminal value.
  always_comb begin
    strobe.load    = cntIsOne | cntIsZero;
    strobe.tickSet = cntIsTwo;
  end
endmodule

// File: rtl/div_datapath.sv
module div_datapath #(
  parameter int WORD_W  = 17,
  parameter int AM_DROP = 2,
  parameter int FM_MIN  = 256,
  parameter int AM_MIN  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] divWord,
  input  logic              fmMode,
  input  divpkg::divStrobe_t strobe,
  output logic              cntIsZero,
  output logic              cntIsOne,
  output logic              cntIsTwo,
  output logic              mainTick,
  output logic [WORD_W-1:0] cntVal,
  output logic [WORD_W-1:0] ratioEff
);
  localparam int NARROW_W = WORD_W - AM_DROP;
  localparam logic [WORD_W-1:0] FM_FLOOR = WORD_W'(FM_MIN);
  localparam logic [WORD_W-1:0] AM_FLOOR = WORD_W'(AM_MIN);

  logic [WORD_W-1:0] wideRatio;
  logic [WORD_W-1:0] narrowRatio;
  logic [WORD_W-1:0] cntQ;
  logic              tickQ;

  assign wideRatio   = divWord;
  assign narrowRatio = {{AM_DROP{1'b0}}, divWord[WORD_W-1 -: NARROW_W]};

  // Mode select followed by the per-mode floor.
  always_comb begin
    if (fmMode)
      ratioEff = (wideRatio < FM_FLOOR) ? FM_FLOOR : wideRatio;
    else
      ratioEff = (narrowRatio < AM_FLOOR) ? AM_FLOOR : narrowRatio;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ  <= '0;
      tickQ <= 1'b0;
    end else begin
      cntQ  <= strobe.load ? ratioEff : cntQ - 1'b1;
      tickQ <= strobe.tickSet;
    end
  end

  assign cntIsZero = (cntQ == '0);
  assign cntIsOne  = (cntQ == WORD_W'(1));
  assign cntIsTwo  = (cntQ == WORD_W'(2));
  assign mainTick  = tickQ;
  assign cntVal    = cntQ;
endmodule

// File: rtl/div_testmux.sv
module div_testmux (
  input  logic [2:0] testSel,
  input  logic       mainTick,
  input  logic       refTick,
  input  logic       bandSel,
  output logic       bandOut,
  output logic       pumpForce,
  output logic       pumpUp,
  output logic       pumpDn
);
  import divpkg::*;
  testCode_t code;
  assign code = testCode_t'(testSel);

  always_comb begin
    bandOut   = bandSel;
    pumpForce = 1'b0;
    pumpUp    = 1'b0;
    pumpDn    = 1'b0;
    case (code)
      TC_SRC:    begin pumpForce = 1'b1; pumpUp = 1'b1; end
      TC_SNK:    begin pumpForce = 1'b1; pumpDn = 1'b1; end
      TC_HIZ:    pumpForce = 1'b1;
      TC_BOTH:   begin pumpForce = 1'b1; pumpUp = 1'b1; pumpDn = 1'b1; end
      TC_BSMAIN: bandOut = mainTick;
      TC_BSREF:  bandOut = refTick;
      default:   bandOut = bandSel;
    endcase
  end
endmodule

// File: rtl/prog_divider.sv
module prog_divider #(
  parameter int WORD_W  = 17,
  parameter int AM_DROP = 2,
  parameter int FM_MIN  = 256,
  parameter int AM_MIN  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] divWord,
  input  logic              fmMode,
  input  logic              bandSel,
  input  logic [2:0]        testSel,
  input  logic              refTick,
  output logic              mainTick,
  output logic              bandOut,
  output logic              pumpForce,
  output logic              pumpUp,
  output logic              pumpDn
);
  divpkg::divStrobe_t strobe;
  logic cntIsZero, cntIsOne, cntIsTwo;
  logic [WORD_W-1:0] cntVal;
  logic [WORD_W-1:0] ratioEff;

  div_ctrl u_ctrl (
    .cntIsZero(cntIsZero), .cntIsOne(cntIsOne), .cntIsTwo(cntIsTwo),
    .strobe(strobe)
  );

  div_datapath #(.WORD_W(WORD_W), .AM_DROP(AM_DROP), .FM_MIN(FM_MIN), .AM_MIN(AM_MIN)) u_dp (
    .clk(clk), .rstN(rstN), .divWord(divWord), .fmMode(fmMode), .strobe(strobe),
    .cntIsZero(cntIsZero), .cntIsOne(cntIsOne), .cntIsTwo(cntIsTwo),
    .mainTick(mainTick), .cntVal(cntVal), .ratioEff(ratioEff)
  );

  div_testmux u_mux (
    .testSel(testSel), .mainTick(mainTick), .refTick(refTick), .bandSel(bandSel),
    .bandOut(bandOut), .pumpForce(pumpForce), .pumpUp(pumpUp), .pumpDn(pumpDn)
  );
endmodule

// File: rtl/div_chk.sv
module div_chk #(
  parameter int WORD_W = 17,
  parameter int AM_MIN = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              mainTick,
  input logic [WORD_W-1:0] cntVal,
  input logic [WORD_W-1:0] ratioEff,
  input logic [2:0]        testSel,
  input logic              pumpForce,
  input logic              pumpUp,
  input logic              pumpDn
);
  // R7
  tick_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    mainTick |=> !mainTick);

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cntVal > WORD_W'(1)) |=> (cntVal == $past(cntVal) - WORD_W'(1)));

  // R6
  reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    mainTick |=> (cntVal == $past(ratioEff)));

  // R5
  floor_chk: assert property (@(posedge clk) disable iff (!rstN)
    mainTick |-> (ratioEff >= WORD_W'(AM_MIN)));

  // R9
  hiz_chk: assert property (@(posedge clk) disable iff (!rstN)
    (testSel == 3'd3) |-> (pumpForce && !pumpUp && !pumpDn));
endmodule

bind prog_divider div_chk #(.WORD_W(WORD_W), .AM_MIN(AM_MIN)) u_chk (
  .clk(clk), .rstN(rstN), .mainTick(mainTick), .cntVal(cntVal), .ratioEff(ratioEff),
  .testSel(testSel), .pumpForce(pumpForce), .pumpUp(pumpUp), .pumpDn(pumpDn)
);

// File: tb/sim_prog_divider.sv
module sim_prog_divider;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [16:0] divWord = 17'd300;
  logic fmMode = 1'b1;
  logic bandSel = 1'b0;
  logic [2:0] testSel = 3'd0;
  logic refTick = 1'b0;
  logic mainTick, bandOut, pumpForce, pumpUp, pumpDn;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int mcnt = 0;
  string curTag = "R2";
  bit done = 0;

  always #5 clk = ~clk;

  prog_divider u0 (
    .clk(clk), .rstN(rstN), .divWord(divWord), .fmMode(fmMode), .bandSel(bandSel),
    .testSel(testSel), .refTick(refTick), .mainTick(mainTick), .bandOut(bandOut),
    .pumpForce(pumpForce), .pumpUp(pumpUp), .pumpDn(pumpDn)
  );

  function automatic int refRatio(logic [16:0] w, logic fm);
    int r;
    if (fm) begin r = int'(w); if (r < 256) r = 256; end
    else begin r = int'(w) / 4; if (r < 64) r = 64; end
    return r;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Behavioural model: remaining count, reloaded at end of period.
  always @(posedge clk) begin
    cycles++;
    if (!rstN) mcnt = 0;
    else if (mcnt <= 1) mcnt = refRatio(divWord, fmMode);
    else mcnt = mcnt - 1;
  end

  // Per-cycle comparison away from the active edge.
  always @(negedge clk) begin
    if (rstN && !done) begin
      logic [2:0] ex;
      logic exBand;
      check(curTag, int'(mainTick), int'(mcnt == 1));
      case (testSel)
        3'd1: ex = 3'b110; 3'd2: ex = 3'b101; 3'd3: ex = 3'b100; 3'd4: ex = 3'b111;
        default: ex = 3'b000;
      endcase
      exBand = (testSel == 3'd5) ? mainTick : (testSel == 3'd6) ? refTick : bandSel;
      check((testSel == 0 || testSel == 7) ? "R10" : "R9", int'({pumpForce, pumpUp, pumpDn}), int'(ex));
      check((testSel == 0 || testSel == 7) ? "R10" : "R8", int'(bandOut), int'(exBand));
    end
  end

  // Number of clock cycles from one tick to the next.
  task automatic measure(output int p);
    do @(negedge clk); while (!mainTick);
    p = 0;
    do begin @(negedge clk); p++; end while (!mainTick);
  endtask

  task automatic finishRun();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    while (cycles < 150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual %0d expected below 150000", cycles);
    finishRun();
  end

  initial begin
    int p, first;
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1", int'(mainTick), 0);
    rstN = 1'b1;
    curTag = "R1";
    first = 0;
    do begin @(negedge clk); first++; end while (!mainTick);
    check("R1", first, 300);
    @(negedge clk);
    check("R7", int'(mainTick), 0);

    curTag = "R2";
    measure(p); check("R2", p, 300);
    divWord = 17'd1000;
    measure(p); measure(p); check("R2", p, 1000);

    curTag = "R4";
    divWord = 17'd100;
    measure(p); measure(p); check("R4", p, 256);

    curTag = "R3";
    fmMode = 1'b0; divWord = 17'd283;
    measure(p); measure(p); check("R3", p, 70);
    divWord = 17'd280;
    measure(p); measure(p); check("R3", p, 70);

    curTag = "R5";
    divWord = 17'd20;
    measure(p); measure(p); check("R5", p, 64);

    // R6: change mid-period; current period keeps the old ratio.
    curTag = "R6";
    fmMode = 1'b1; divWord = 17'd300;
    measure(p); measure(p);
    do @(negedge clk); while (!mainTick);
    repeat (100) @(negedge clk);
    divWord = 17'd400;
    p = 100;
    do begin @(negedge clk); p++; end while (!mainTick);
    check("R6", p, 300);
    measure(p); check("R6", p, 400);

    // R8, R9, R10: walk all test codes with toggling side inputs.
    curTag = "R7";
    divWord = 17'd256;
    for (int c = 0; c < 8; c++) begin
      testSel = 3'(c);
      for (int k = 0; k < 300; k++) begin
        @(negedge clk);
        refTick = (k % 7 == 0);
        bandSel = (k % 5 < 2);
      end
    end
    testSel = 3'd0;
    repeat (5) @(negedge clk);
    finishRun();
  end
endmodule